// File: doc/BRIEF.md
# Mailbox Request Controller

This block runs one transaction on a 256-bit shared mailbox from the requesting side. A transaction either opens or closes a control queue set. An open request carries four page-aligned physical queue addresses (event, completion, receive and send queues), a 16-bit interrupt vector and a reset flag. A close request carries only the reset flag. The mailbox is reached through a simple request/acknowledge register port with eight 32-bit slots. Slot 7 holds the control header, and its bit 31 is the ownership flag: when it is set, the far side owns the mailbox.

After `start`, the controller checks its arguments. It then polls slot 7 until it owns the mailbox, and writes the request. An open request uses slots 0 to 7 in order, ending with the header. A close request writes the header alone. The controller then polls slot 7 again for the answer and validates it. Polls are separated by a programmable idle gap, and each polling phase allows a bounded number of reads. The outcome is reported by a one-cycle `done` pulse with a 2-bit `result`.

Top module: `mbox_req_ctrl`

## Requirements
- R1: An open request (`cmd_close`=0) is rejected before any bus access if any queue address has a bit in [11:0] set, or if `irq_vec` has any bit in [31:16] set. In that case `done` rises on the clock edge that samples `start`, with `result`=3 (bad argument). A close request ignores the addresses and the vector.
- R2: Before writing, the controller issues reads of slot 7 (`bus_we`=0, `bus_addr`=7). It repeats them until a returned word has bit 31 clear. An all-ones word in this phase counts as busy, even with the reset flag set.
- R3: For an open request, each queue's frame number is its address bits [63:12]. Frame bits [47:0] occupy message bits [48q+47:48q], with q = 0 for the event queue, 1 for completion, 2 for receive and 3 for send. Slot k carries message bits [32k+31:32k].
- R4: Message bits [207:192] hold the four frame-number high nibbles (frame bits [51:48]), with queue q at bits [192+4q+3:192+4q]. Bits [223:208] hold `irq_vec[15:0]`.
- R5: The header (slot 7, message bits [255:224]) carries the type in bits [2:0] (1 for open, 2 for close), version 0 in bits [5:3] and the reset flag in bit 24. All other bits are zero, including direction bit 7 and status bits [15:8].
- R6: An open request writes slots 0 to 7 in ascending order. A close request writes only slot 7.
- R7: After a busy poll read is acknowledged, `bus_req` stays low for exactly `POLL_GAP` cycles before the next read is raised.
- R8: If `POLL_LIMIT` reads in one polling phase all return busy, the transaction ends with `result`=1 (timeout). No further bus access follows, and no write is made if the limit is reached before ownership.
- R9: A response read with bit 31 clear ends with `result`=0 (success) only if all of these hold: bits [2:0] equal the request type, bits [5:3] are not above the request version, bit 7 is 1, and bits [15:8] are 0. Otherwise it ends with `result`=2 (protocol error).
- R10: With the reset flag set, a response read of 32'hFFFFFFFF ends the transaction with success. Without the flag, that word is treated as busy.
- R11: After reset, `done` and `bus_req` are low. `done` is a one-cycle pulse. A raised `bus_req` holds `bus_we`, `bus_addr` and `bus_wdata` stable until `bus_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transaction (sampled while idle) |
| cmd_close | input | 1 | 0 = open request, 1 = close request |
| reset_req | input | 1 | Reset flag placed in the header |
| eq_addr | input | ADDR_W | Event queue physical address |
| cq_addr | input | ADDR_W | Completion queue physical address |
| rq_addr | input | ADDR_W | Receive queue physical address |
| sq_addr | input | ADDR_W | Send queue physical address |
| irq_vec | input | VEC_W | Event queue interrupt vector |
| bus_req | output | 1 | Register access request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 3 | Mailbox slot index |
| bus_wdata | output | 32 | Write data |
| bus_ack | input | 1 | Access complete; read data valid |
| bus_rdata | input | 32 | Read data |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | 0 success, 1 timeout, 2 protocol error, 3 bad argument |

## Verification
A wrong slot counter or latched message shows up at the ports on the very acknowledge where it happens, as a write with the wrong slot index or wrong data. A wrong phase flag shows up as a write that is missing or repeated, or as the all-ones rule applied in the wrong phase. A faulty poll counter or gap timer changes the number of reads, or the idle run before the next read, in the same polling phase. A validation fault turns the final `result` from success to protocol error, or the reverse, on the `done` pulse that follows the last read.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int DW      = 32;
  localparam int NSLOT   = 8;
  localparam int MSG_W   = DW * NSLOT;
  localparam int NQ      = 4;
  localparam int LO_W    = 48;
  localparam int NIB_W   = 4;
  localparam int VFLD_W  = 16;
  localparam int OWN_BIT = 31;
  localparam int RST_BIT = 24;

  localparam logic [2:0] HDR_SLOT   = 3'd7;
  localparam logic [2:0] TYPE_OPEN  = 3'd1;
  localparam logic [2:0] TYPE_CLOSE = 3'd2;
  localparam logic [2:0] REQ_VER    = 3'd0;

  typedef enum logic [1:0] {
    RES_OK      = 2'd0,
    RES_TIMEOUT = 2'd1,
    RES_PROTO   = 2'd2,
    RES_BADARG  = 2'd3
  } res_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READ,
    ST_GAP,
    ST_WRITE
  } state_e;
endpackage

// File: rtl/mbox_packer.sv
module mbox_packer
  import mbox_pkg::*;
#(
  parameter int ADDR_W  = 64,
  parameter int VEC_W   = 32,
  parameter int PAGE_SH = 12
) (
  input  logic [NQ-1:0][ADDR_W-1:0] q_addr,
  input  logic [VEC_W-1:0]          vec,
  input  logic                      is_close,
  input  logic                      rst_flag,
  output logic [MSG_W-1:0]          msg,
  output logic                      bad_arg
);
  localparam int FRM_W = ADDR_W - PAGE_SH;

  logic [NQ-1:0]       misalign;
  logic [NQ*LO_W-1:0]  lo_field;
  logic [NQ*NIB_W-1:0] hi_field;
  logic [DW-1:0]       hdr;

  for (genvar q = 0; q < NQ; q++) begin : g_q
    logic [FRM_W-1:0] frame;
    assign frame = q_addr[q][ADDR_W-1:PAGE_SH];
    assign lo_field[q*LO_W +: LO_W]   = frame[LO_W-1:0];
    assign hi_field[q*NIB_W +: NIB_W] = frame[FRM_W-1:LO_W];
    assign misalign[q] = |q_addr[q][PAGE_SH-1:0];
  end

  always_comb begin
    hdr          = '0;
    hdr[2:0]     = is_close ? TYPE_CLOSE : TYPE_OPEN;
    hdr[5:3]     = REQ_VER;
    hdr[RST_BIT] = rst_flag;
  end

  assign msg     = {hdr, vec[VFLD_W-1:0], hi_field, lo_field};
  assign bad_arg = !is_close && ((|misalign) || (|vec[VEC_W-1:VFLD_W]));
endmodule

// File: rtl/mbox_resp_check.sv
module mbox_resp_check
  import mbox_pkg::*;
(
  input  logic [2:0] req_type,
  input  logic [2:0] rsp_type,
  input  logic [2:0] rsp_ver,
  input  logic       rsp_dir,
  input  logic [7:0] rsp_status,
  output logic       accept
);
  assign accept = (rsp_type == req_type) && (rsp_ver <= REQ_VER) &&
                  rsp_dir && (rsp_status == 8'd0);
endmodule

// File: rtl/mbox_req_ctrl.sv
module mbox_req_ctrl
  import mbox_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int VEC_W      = 32,
  parameter int PAGE_SH    = 12,
  parameter int POLL_LIMIT = 20000,
  parameter int POLL_GAP   = 250000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              cmd_close,
  input  logic              reset_req,
  input  logic [ADDR_W-1:0] eq_addr,
  input  logic [ADDR_W-1:0] cq_addr,
  input  logic [ADDR_W-1:0] rq_addr,
  input  logic [ADDR_W-1:0] sq_addr,
  input  logic [VEC_W-1:0]  irq_vec,
  output logic              bus_req,
  output logic              bus_we,
  output logic [2:0]        bus_addr,
  output logic [DW-1:0]     bus_wdata,
  input  logic              bus_ack,
  input  logic [DW-1:0]     bus_rdata,
  output logic              done,
  output logic [1:0]        result
);
  localparam int CNT_W = $clog2(POLL_LIMIT + 1);
  localparam int GAP_W = $clog2(POLL_GAP + 1);
  localparam logic [CNT_W-1:0] LAST_POLL = CNT_W'(POLL_LIMIT - 1);
  localparam logic [GAP_W-1:0] GAP_LOAD  = GAP_W'(POLL_GAP - 1);

  state_e             state;
  logic               in_resp;
  logic               is_close_q;
  logic               rst_flag_q;
  logic [MSG_W-1:0]   msg_c, msg_q;
  logic               bad_arg;
  logic               accept;
  logic [CNT_W-1:0]   poll_cnt;
  logic [GAP_W-1:0]   gap_cnt;
  logic [2:0]         first_slot, next_slot;

  mbox_packer #(.ADDR_W(ADDR_W), .VEC_W(VEC_W), .PAGE_SH(PAGE_SH)) u_pack (
    .q_addr  ({sq_addr, rq_addr, cq_addr, eq_addr}),
    .vec     (irq_vec),
    .is_close(cmd_close),
    .rst_flag(reset_req),
    .msg     (msg_c),
    .bad_arg (bad_arg)
  );

  mbox_resp_check u_chk_rsp (
    .req_type  (is_close_q ? TYPE_CLOSE : TYPE_OPEN),
    .rsp_type  (bus_rdata[2:0]),
    .rsp_ver   (bus_rdata[5:3]),
    .rsp_dir   (bus_rdata[7]),
    .rsp_status(bus_rdata[15:8]),
    .accept    (accept)
  );

  assign first_slot = is_close_q ? HDR_SLOT : 3'd0;
  assign next_slot  = bus_addr + 3'd1;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      in_resp    <= 1'b0;
      is_close_q <= 1'b0;
      rst_flag_q <= 1'b0;
      msg_q      <= '0;
      poll_cnt   <= '0;
      gap_cnt    <= '0;
      bus_req    <= 1'b0;
      bus_we     <= 1'b0;
      bus_addr   <= '0;
      bus_wdata  <= '0;
      done       <= 1'b0;
      result     <= RES_OK;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          is_close_q <= cmd_close;
          rst_flag_q <= reset_req;
          msg_q      <= msg_c;
          if (bad_arg) begin
            done   <= 1'b1;
            result <= RES_BADARG;
          end else begin
            state    <= ST_READ;
            in_resp  <= 1'b0;
            poll_cnt <= '0;
            bus_req  <= 1'b1;
            bus_we   <= 1'b0;
            bus_addr <= HDR_SLOT;
          end
        end
        ST_READ: if (bus_ack) begin
          bus_req <= 1'b0;
          if (in_resp && rst_flag_q && (&bus_rdata)) begin
            state  <= ST_IDLE;
            done   <= 1'b1;
            result <= RES_OK;
          end else if (!bus_rdata[OWN_BIT]) begin
            if (!in_resp) begin
              state     <= ST_WRITE;
              bus_req   <= 1'b1;
              bus_we    <= 1'b1;
              bus_addr  <= first_slot;
              bus_wdata <= msg_q[DW*int'(first_slot) +: DW];
            end else begin
              state  <= ST_IDLE;
              done   <= 1'b1;
              result <= accept ? RES_OK : RES_PROTO;
            end
          end else if (poll_cnt == LAST_POLL) begin
            state  <= ST_IDLE;
            done   <= 1'b1;
            result <= RES_TIMEOUT;
          end else begin
            poll_cnt <= poll_cnt + 1'b1;
            gap_cnt  <= GAP_LOAD;
            state    <= ST_GAP;
          end
        end
        ST_GAP: begin
          if (gap_cnt == '0) begin
            state    <= ST_READ;
            bus_req  <= 1'b1;
            bus_we   <= 1'b0;
            bus_addr <= HDR_SLOT;
          end else begin
            gap_cnt <= gap_cnt - 1'b1;
          end
        end
        ST_WRITE: if (bus_ack) begin
          if (bus_addr == HDR_SLOT) begin
            state    <= ST_READ;
            in_resp  <= 1'b1;
            poll_cnt <= '0;
            bus_we   <= 1'b0;
          end else begin
            bus_addr  <= next_slot;
            bus_wdata <= msg_q[DW*int'(next_slot) +: DW];
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mbox_req_ctrl_chk.sv
module mbox_req_ctrl_chk (
  input logic        clk,
  input logic        rst,
  input logic        bus_req,
  input logic        bus_we,
  input logic [2:0]  bus_addr,
  input logic [31:0] bus_wdata,
  input logic        bus_ack,
  input logic        done,
  input logic [1:0]  result
);
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R11

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    bus_req && !bus_ack |=> bus_req && $stable(bus_we) && $stable(bus_addr) && $stable(bus_wdata)); // R11

  AST_READ_HDR_ONLY: assert property (@(posedge clk) disable iff (rst)
    bus_req && !bus_we |-> bus_addr == 3'd7); // R2

  AST_HDR_IS_REQUEST: assert property (@(posedge clk) disable iff (rst)
    bus_req && bus_we && bus_addr == 3'd7 |-> !bus_wdata[7] && bus_wdata[15:8] == 8'd0 && bus_wdata[5:3] == 3'd0); // R5

  AST_QUIET_AT_DONE: assert property (@(posedge clk) disable iff (rst)
    done |-> !bus_req); // R8

  AST_BADARG_NO_BUS: assert property (@(posedge clk) disable iff (rst)
    done && result == 2'd3 |-> !$past(bus_req)); // R1
endmodule

bind mbox_req_ctrl mbox_req_ctrl_chk u_req_chk (
  .clk      (clk),
  .rst      (rst),
  .bus_req  (bus_req),
  .bus_we   (bus_we),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .bus_ack  (bus_ack),
  .done     (done),
  .result   (result)
);

// File: tb/mbox_req_ctrl_tb.sv
`timescale 1ns/1ps
module mbox_req_ctrl_tb;
  localparam int LIM = 6;
  localparam int GAP = 3;
  localparam logic [31:0] ONES = 32'hFFFF_FFFF;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, cmd_close = 1'b0, reset_req = 1'b0;
  logic [63:0] eq_addr = '0, cq_addr = '0, rq_addr = '0, sq_addr = '0;
  logic [31:0] irq_vec = '0;
  logic bus_req, bus_we, bus_ack = 1'b0, done;
  logic [2:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata = '0;
  logic [1:0] result;

  int checks = 0, failures = 0;

  always #2 clk = ~clk;

  mbox_req_ctrl #(.POLL_LIMIT(LIM), .POLL_GAP(GAP)) u_dut (
    .clk(clk), .rst(rst), .start(start), .cmd_close(cmd_close), .reset_req(reset_req),
    .eq_addr(eq_addr), .cq_addr(cq_addr), .rq_addr(rq_addr), .sq_addr(sq_addr),
    .irq_vec(irq_vec), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
    .done(done), .result(result)
  );

  // far-side model configuration
  int pre_busy, post_busy, pre_cnt, post_cnt, low_run;
  logic [31:0] busy_word, resp_word, w;
  logic hdr_seen, cur_rst, prev_busy;

  // expected transactions
  logic        exp_we[$];
  logic [2:0]  exp_addr[$];
  logic [31:0] exp_data[$];
  string       exp_tag[$];
  logic [7:0]  mb[32];

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      bus_ack <= 1'b0;
      low_run <= 0;
    end else begin
      if (bus_req && !bus_ack) begin
        bus_ack <= 1'b1;
        if (!bus_we) begin
          if (prev_busy) chk(low_run == GAP, "R7", "idle cycles between polls", low_run, GAP);
          if (!hdr_seen) begin
            w = (pre_cnt < pre_busy) ? busy_word : 32'h0000_0000;
            pre_cnt++;
          end else begin
            w = (post_cnt < post_busy) ? busy_word : resp_word;
            post_cnt++;
          end
          bus_rdata <= w;
          prev_busy <= w[31] && !(hdr_seen && cur_rst && w == ONES);
        end else begin
          prev_busy <= 1'b0;
        end
      end else begin
        bus_ack <= 1'b0;
      end
      if (bus_req && bus_ack) begin
        if (exp_we.size() == 0) begin
          chk(1'b0, "R8", "unexpected bus access at slot", bus_addr, 0);
        end else begin
          string t;
          logic ew; logic [2:0] ea; logic [31:0] ed;
          t = exp_tag.pop_front(); ew = exp_we.pop_front();
          ea = exp_addr.pop_front(); ed = exp_data.pop_front();
          chk(bus_we == ew, t, "access direction", bus_we, ew);
          chk(bus_addr == ea, t, "slot index", bus_addr, ea);
          if (ew) chk(bus_wdata == ed, t, "write data", bus_wdata, ed);
        end
        if (bus_we && bus_addr == 3'd7) hdr_seen <= 1'b1;
      end
      low_run <= bus_req ? 0 : low_run + 1;
    end
  end

  task automatic push(logic we, logic [2:0] a, logic [31:0] d, string t);
    exp_we.push_back(we); exp_addr.push_back(a); exp_data.push_back(d); exp_tag.push_back(t);
  endtask

  task automatic run_case(string tag, logic close, logic rstf,
                          logic [63:0] a0, logic [63:0] a1, logic [63:0] a2, logic [63:0] a3,
                          logic [31:0] vec, int pb, int qb, logic [31:0] bw, logic [31:0] rw);
    logic [63:0] ad[4];
    logic [51:0] fr;
    logic [15:0] nib;
    logic [31:0] hdr, word;
    logic [1:0] exp_res;
    bit bad, decided;
    int waited;
    ad[0] = a0; ad[1] = a1; ad[2] = a2; ad[3] = a3;
    exp_we.delete(); exp_addr.delete(); exp_data.delete(); exp_tag.delete();
    // behavioural model of the whole transaction
    bad = !close && (vec[31:16] != 0 || a0[11:0] != 0 || a1[11:0] != 0 || a2[11:0] != 0 || a3[11:0] != 0);
    exp_res = 2'd0;
    if (bad) exp_res = 2'd3;
    else begin
      for (int k = 0; k < ((pb >= LIM) ? LIM : pb + 1); k++) push(1'b0, 3'd7, 0, "R2");
      if (pb >= LIM) exp_res = 2'd1;
      else begin
        foreach (mb[i]) mb[i] = 8'h00;
        nib = '0;
        for (int q = 0; q < 4; q++) begin
          fr = ad[q] >> 12;
          for (int b = 0; b < 6; b++) mb[6*q+b] = 8'(fr >> (8*b));
          nib = nib | (16'(fr >> 48) << (4*q));
        end
        mb[24] = nib[7:0]; mb[25] = nib[15:8];
        mb[26] = vec[7:0]; mb[27] = vec[15:8];
        hdr = (close ? 32'd2 : 32'd1) | (32'(rstf) << 24);
        mb[28] = hdr[7:0]; mb[29] = hdr[15:8]; mb[30] = hdr[23:16]; mb[31] = hdr[31:24];
        if (close) push(1'b1, 3'd7, hdr, "R6");
        else for (int k = 0; k < 8; k++)
          push(1'b1, 3'(k), {mb[4*k+3], mb[4*k+2], mb[4*k+1], mb[4*k]},
               (k < 6) ? "R3" : (k == 6) ? "R4" : "R5");
        decided = 0;
        exp_res = 2'd1;
        for (int k = 0; k < LIM && !decided; k++) begin
          word = (k < qb) ? bw : rw;
          push(1'b0, 3'd7, 0, "R9");
          if (rstf && word == ONES) begin exp_res = 2'd0; decided = 1; end
          else if (!word[31]) begin
            exp_res = (word[2:0] == (close ? 3'd2 : 3'd1) && word[5:3] == 0 && word[7] &&
                       word[15:8] == 0) ? 2'd0 : 2'd2;
            decided = 1;
          end
        end
      end
    end
    // configure far side and launch
    @(negedge clk);
    pre_busy = pb; post_busy = qb; busy_word = bw; resp_word = rw;
    pre_cnt = 0; post_cnt = 0; hdr_seen = 1'b0; cur_rst = rstf; prev_busy = 1'b0;
    cmd_close = close; reset_req = rstf; eq_addr = a0; cq_addr = a1; rq_addr = a2; sq_addr = a3;
    irq_vec = vec; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waited = 0;
    while (!done && waited < 500) begin @(negedge clk); waited++; end
    chk(done == 1'b1, tag, "done seen", done, 1);
    if (bad) chk(waited == 0, "R1", "cycles from start to done", waited, 0);
    chk(result == exp_res, tag, "result code", result, exp_res);
    @(negedge clk);
    chk(done == 1'b0, "R11", "done width", done, 0);
    repeat (4) begin
      @(negedge clk);
      chk(!bus_req, "R8", "bus idle after done", bus_req, 0);
    end
    chk(exp_we.size() == 0, tag, "missing transactions", exp_we.size(), 0);
  endtask

  initial begin
    pre_busy = 0; post_busy = 0; busy_word = 32'h8000_0000; resp_word = 0;
    pre_cnt = 0; post_cnt = 0; hdr_seen = 0; cur_rst = 0; prev_busy = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!done && !bus_req, "R11", "reset state done/bus_req", {done, bus_req}, 0);
    // open, two busy ownership polls, one busy response poll
    run_case("R3", 0, 0, 64'hA123_4567_89AB_C000, 64'h5FED_CBA9_8765_4000,
             64'h0000_0000_0000_1000, 64'hFFFF_FFFF_FFFF_F000, 32'h0000_BEEF,
             2, 1, 32'h8000_0000, 32'h0000_0081);
    // reset flag, all-ones answer accepted
    run_case("R10", 0, 1, 64'h0000_1234_5000_0000, 64'h0000_0000_0000_2000,
             64'h0003_0000_0000_3000, 64'h0000_0000_0040_0000, 32'h0000_0001,
             0, 1, 32'h8000_0000, ONES);
    // close with unaligned addresses and a wide vector: both ignored
    run_case("R6", 1, 0, 64'h0000_0000_0000_0FFF, 64'h1, 64'h2, 64'h3, 32'hFFFF_FFFF,
             1, 0, 32'h8000_0000, 32'h0000_0082);
    // protocol errors: newer version, wrong type, non-zero status, request direction
    run_case("R9", 0, 0, 64'h1000, 64'h2000, 64'h3000, 64'h4000, 32'h5, 0, 0, 32'h8000_0000, 32'h0000_0089);
    run_case("R9", 1, 0, 64'h0, 64'h0, 64'h0, 64'h0, 32'h0, 0, 0, 32'h8000_0000, 32'h0000_0081);
    run_case("R9", 0, 0, 64'h1000, 64'h2000, 64'h3000, 64'h4000, 32'h5, 0, 0, 32'h8000_0000, 32'h0000_0181);
    run_case("R9", 0, 0, 64'h1000, 64'h2000, 64'h3000, 64'h4000, 32'h5, 0, 0, 32'h8000_0000, 32'h0000_0001);
    // bad arguments
    run_case("R1", 0, 0, 64'h1000, 64'h2800, 64'h3000, 64'h4000, 32'h5, 0, 0, 32'h8000_0000, 32'h81);
    run_case("R1", 0, 0, 64'h1000, 64'h2000, 64'h3000, 64'h4000, 32'h0001_0000, 0, 0, 32'h8000_0000, 32'h81);
    // ownership never granted
    run_case("R8", 0, 0, 64'h1000, 64'h2000, 64'h3000, 64'h4000, 32'h5, LIM, 0, 32'h8000_0000, 32'h81);
    // all-ones without reset flag is busy
    run_case("R10", 0, 0, 64'h1000, 64'h2000, 64'h3000, 64'h4000, 32'h5, 0, 10, ONES, 32'h81);
    // all-ones while waiting for ownership is busy even with reset flag
    run_case("R2", 0, 1, 64'h1000, 64'h2000, 64'h3000, 64'h4000, 32'h5, 2, 0, ONES, 32'h81);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired: actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule